// File: doc/BRIEF.md
# Bit-Group Shift, Rotate and Bit-Manipulation Unit

This unit executes the second-byte operation group of an 8-bit processor's shift/rotate/bit family. It receives the operation byte, the 8-bit operand already fetched by the surrounding datapath, and the current sign, zero, parity and carry flags. One clock later it presents the 8-bit result, the new flag values and a write-back enable. A decoded indication that the operand code selects the memory operand is also returned, so the sequencer knows where the write-back goes.

The operation byte is read as three octal digits `g s r`. `g` (bits 7:6) picks the group: shift/rotate, bit test, bit clear or bit set. `s` (bits 5:3) picks the shift variant or the bit index. `r` (bits 2:0) is the operand code. Shift slot 6 holds a shift-left that fills the vacated bit with 1 instead of 0.

Top module: `bitshift_unit`

## Requirements
- R1: In the cycle after a synchronous reset, `res_valid`, `wr_en`, `result`, all four flag outputs and `mem_sel` are 0.
- R2: An operation presented with `op_valid`=1 appears on the outputs with `res_valid`=1 one clock edge later. A cycle with `op_valid`=0 gives `res_valid`=0 and `wr_en`=0 after the next edge.
- R3: With `op_code[7:6]`=0, shift code 0 rotates left and shift code 1 rotates right. The bit shifted out goes both to carry and into the vacated position.
- R4: Shift codes 2 (left) and 3 (right) rotate through carry. `carry_in` fills the vacated bit and the bit shifted out becomes the new carry.
- R5: Shift code 4 shifts left and shift code 7 shifts right, each filling the vacated bit with 0. The bit shifted out becomes the carry.
- R6: Shift code 5 shifts right, keeps bit 7 unchanged and puts bit 0 into carry.
- R7: Shift code 6 shifts left, sets bit 0 of the result to 1 and puts the old bit 7 into carry.
- R8: For every shift or rotate, `flag_s` equals result bit 7, `flag_z` is 1 when the result is zero, `flag_p` is 1 when the result holds an even number of ones, and `wr_en` is 1.
- R9: With `op_code[7:6]`=1 (bit test of bit `op_code[5:3]`), `flag_z` is the inverse of the tested bit, `wr_en` is 0, `result` equals the operand, and the sign, parity and carry outputs equal their incoming values.
- R10: With `op_code[7:6]`=2 the indexed bit is cleared, and with 3 it is set. All other bits pass unchanged, `wr_en` is 1, and all four flags equal their incoming values.
- R11: `mem_sel` is 1 exactly when the accepted operation's operand code `op_code[2:0]` is 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Operation present this cycle |
| op_code | input | 8 | Second operation byte (group, selector, operand code) |
| operand | input | 8 | Operand value |
| sign_in | input | 1 | Incoming sign flag |
| zero_in | input | 1 | Incoming zero flag |
| parity_in | input | 1 | Incoming parity flag |
| carry_in | input | 1 | Incoming carry flag |
| res_valid | output | 1 | Registered outputs hold a new result |
| result | output | 8 | Result byte |
| flag_s | output | 1 | New sign flag |
| flag_z | output | 1 | New zero flag |
| flag_p | output | 1 | New parity flag |
| flag_c | output | 1 | New carry flag |
| wr_en | output | 1 | Result must be written back |
| mem_sel | output | 1 | Operand code selects the memory operand |

## Verification
Every output passes through exactly one register, so each result, flag, write enable and `mem_sel` is due at the first rising edge after the operation is applied. The bench drives inputs on the falling edge and reads the outputs on the following falling edge, half a period after that capture edge, then compares them with a reference function. Idle cycles are checked the same way, one edge later, for a cleared `res_valid` and `wr_en`.

// File: rtl/bitshift_pkg.sv
package bitshift_pkg;
  typedef enum logic [1:0] {
    GRP_SHIFT = 2'd0,
    GRP_TEST  = 2'd1,
    GRP_CLR   = 2'd2,
    GRP_SET   = 2'd3
  } grp_e;

  typedef enum logic [2:0] {
    SH_ROL  = 3'd0,
    SH_ROR  = 3'd1,
    SH_RCL  = 3'd2,
    SH_RCR  = 3'd3,
    SH_SHL0 = 3'd4,
    SH_SAR  = 3'd5,
    SH_SHL1 = 3'd6,
    SH_SHR0 = 3'd7
  } shk_e;

  localparam logic [2:0] MEM_OPND_CODE = 3'd6;

  typedef struct packed {
    logic s;
    logic z;
    logic p;
    logic c;
  } flags_t;
endpackage

// File: rtl/bitshift_shifter.sv
module bitshift_shifter
  import bitshift_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic [DW-1:0] din,
  input  shk_e          kind,
  input  logic          cin,
  output logic [DW-1:0] dout,
  output logic          cout
);
  localparam int MSB = DW - 1;

  logic          fill_lo;
  logic          fill_hi;
  logic          go_left;

  always_comb begin
    go_left = 1'b0;
    fill_lo = 1'b0;
    fill_hi = 1'b0;
    unique case (kind)
      SH_ROL:  begin go_left = 1'b1; fill_lo = din[MSB]; end
      SH_ROR:  begin go_left = 1'b0; fill_hi = din[0];   end
      SH_RCL:  begin go_left = 1'b1; fill_lo = cin;      end
      SH_RCR:  begin go_left = 1'b0; fill_hi = cin;      end
      SH_SHL0: begin go_left = 1'b1; fill_lo = 1'b0;     end
      SH_SAR:  begin go_left = 1'b0; fill_hi = din[MSB]; end
      SH_SHL1: begin go_left = 1'b1; fill_lo = 1'b1;     end
      SH_SHR0: begin go_left = 1'b0; fill_hi = 1'b0;     end
      default: begin go_left = 1'b0; end
    endcase
  end

  always_comb begin
    if (go_left) begin
      dout = {din[MSB-1:0], fill_lo};
      cout = din[MSB];
    end else begin
      dout = {fill_hi, din[MSB:1]};
      cout = din[0];
    end
  end
endmodule

// File: rtl/bitshift_bitop.sv
module bitshift_bitop #(
  parameter int DW   = 8,
  parameter int IDXW = $clog2(DW)
) (
  input  logic [DW-1:0]   din,
  input  logic [IDXW-1:0] idx,
  output logic            picked,
  output logic [DW-1:0]   cleared,
  output logic [DW-1:0]   setv
);
  logic [DW-1:0] hit;

  genvar i;
  generate
    for (i = 0; i < DW; i++) begin : g_lane
      assign hit[i]     = (idx == IDXW'(i));
      assign cleared[i] = din[i] & ~hit[i];
      assign setv[i]    = din[i] |  hit[i];
    end
  endgenerate

  assign picked = |(din & hit);
endmodule

// File: rtl/bitshift_unit.sv
module bitshift_unit
  import bitshift_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          op_valid,
  input  logic [7:0]    op_code,
  input  logic [DW-1:0] operand,
  input  logic          sign_in,
  input  logic          zero_in,
  input  logic          parity_in,
  input  logic          carry_in,
  output logic          res_valid,
  output logic [DW-1:0] result,
  output logic          flag_s,
  output logic          flag_z,
  output logic          flag_p,
  output logic          flag_c,
  output logic          wr_en,
  output logic          mem_sel
);
  localparam int IDXW = $clog2(DW);

  grp_e          grp;
  shk_e          kind;
  logic [2:0]    sel;
  logic [DW-1:0] sh_out;
  logic          sh_c;
  logic          bit_val;
  logic [DW-1:0] clr_out;
  logic [DW-1:0] set_out;
  logic [DW-1:0] nxt_res;
  flags_t        fin;
  flags_t        nxt_f;
  logic          nxt_wr;

  assign grp  = grp_e'(op_code[7:6]);
  assign sel  = op_code[5:3];
  assign kind = shk_e'(sel);
  assign fin  = '{s: sign_in, z: zero_in, p: parity_in, c: carry_in};

  bitshift_shifter #(.DW(DW)) u_shift (
    .din  (operand),
    .kind (kind),
    .cin  (carry_in),
    .dout (sh_out),
    .cout (sh_c)
  );

  bitshift_bitop #(.DW(DW), .IDXW(IDXW)) u_bit (
    .din     (operand),
    .idx     (sel[IDXW-1:0]),
    .picked  (bit_val),
    .cleared (clr_out),
    .setv    (set_out)
  );

  always_comb begin
    nxt_res = operand;
    nxt_f   = fin;
    nxt_wr  = 1'b1;
    unique case (grp)
      GRP_SHIFT: begin
        nxt_res = sh_out;
        nxt_f.s = sh_out[DW-1];
        nxt_f.z = (sh_out == '0);
        nxt_f.p = ~^sh_out;
        nxt_f.c = sh_c;
      end
      GRP_TEST: begin
        nxt_f.z = ~bit_val;
        nxt_wr  = 1'b0;
      end
      GRP_CLR: nxt_res = clr_out;
      GRP_SET: nxt_res = set_out;
      default: nxt_wr  = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      result    <= '0;
      flag_s    <= 1'b0;
      flag_z    <= 1'b0;
      flag_p    <= 1'b0;
      flag_c    <= 1'b0;
      wr_en     <= 1'b0;
      mem_sel   <= 1'b0;
    end else if (op_valid) begin
      res_valid <= 1'b1;
      result    <= nxt_res;
      flag_s    <= nxt_f.s;
      flag_z    <= nxt_f.z;
      flag_p    <= nxt_f.p;
      flag_c    <= nxt_f.c;
      wr_en     <= nxt_wr;
      mem_sel   <= (op_code[2:0] == MEM_OPND_CODE);
    end else begin
      res_valid <= 1'b0;
      wr_en     <= 1'b0;
    end
  end
endmodule

// File: rtl/bitshift_chk.sv
module bitshift_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          op_valid,
  input logic [7:0]    op_code,
  input logic [DW-1:0] operand,
  input logic          sign_in,
  input logic          zero_in,
  input logic          parity_in,
  input logic          carry_in,
  input logic          res_valid,
  input logic [DW-1:0] result,
  input logic          flag_s,
  input logic          flag_z,
  input logic          flag_p,
  input logic          flag_c,
  input logic          wr_en,
  input logic          mem_sel
);
  // R2
  idle_drops_valid_chk: assert property (@(posedge clk) disable iff (rst)
    !op_valid |=> (!res_valid && !wr_en));

  // R2
  op_gives_valid_chk: assert property (@(posedge clk) disable iff (rst)
    op_valid |=> res_valid);

  // R7
  shl_set_lsb_chk: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code[7:3] == 5'b00110) |=> (result[0] && flag_c == $past(operand[DW-1])));

  // R8
  shift_flags_chk: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code[7:6] == 2'd0) |=>
      (wr_en && flag_s == result[DW-1] && flag_z == (result == '0) && flag_p == ~^result));

  // R9
  test_keeps_chk: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code[7:6] == 2'd1) |=>
      (!wr_en && flag_c == $past(carry_in) && result == $past(operand)));

  // R10
  bitmod_flags_chk: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code[7] == 1'b1) |=>
      (wr_en && flag_s == $past(sign_in) && flag_z == $past(zero_in) &&
       flag_p == $past(parity_in) && flag_c == $past(carry_in)));

  // R11
  mem_code_chk: assert property (@(posedge clk) disable iff (rst)
    op_valid |=> (mem_sel == ($past(op_code[2:0]) == 3'd6)));
endmodule

bind bitshift_unit bitshift_chk #(.DW(DW)) u_chk (.*);

// File: tb/bitshift_unit_test.sv
`timescale 1ns/1ps
module bitshift_unit_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       op_valid = 1'b0;
  logic [7:0] op_code = 8'h00;
  logic [7:0] operand = 8'h00;
  logic       sign_in = 1'b0, zero_in = 1'b0, parity_in = 1'b0, carry_in = 1'b0;
  logic       res_valid, flag_s, flag_z, flag_p, flag_c, wr_en, mem_sel;
  logic [7:0] result;

  int tests = 0;
  int fails = 0;

  always #10 clk = ~clk;

  bitshift_unit uut (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
    .operand(operand), .sign_in(sign_in), .zero_in(zero_in),
    .parity_in(parity_in), .carry_in(carry_in), .res_valid(res_valid),
    .result(result), .flag_s(flag_s), .flag_z(flag_z), .flag_p(flag_p),
    .flag_c(flag_c), .wr_en(wr_en), .mem_sel(mem_sel)
  );

  // Expected {valid, result, s, z, p, c, wr, mem}
  function automatic logic [14:0] model(input logic [7:0] oc, input logic [7:0] a,
                                        input logic s, input logic z,
                                        input logic p, input logic c);
    logic [7:0] r;
    logic ns, nz, np, nc, w;
    logic [2:0] k;
    k = oc[5:3];
    r = a; ns = s; nz = z; np = p; nc = c; w = 1'b1;
    case (oc[7:6])
      2'd0: begin
        case (k)
          3'd0: begin r = {a[6:0], a[7]}; nc = a[7]; end
          3'd1: begin r = {a[0], a[7:1]}; nc = a[0]; end
          3'd2: begin r = {a[6:0], c};    nc = a[7]; end
          3'd3: begin r = {c, a[7:1]};    nc = a[0]; end
          3'd4: begin r = {a[6:0], 1'b0}; nc = a[7]; end
          3'd5: begin r = {a[7], a[7:1]}; nc = a[0]; end
          3'd6: begin r = {a[6:0], 1'b1}; nc = a[7]; end
          default: begin r = {1'b0, a[7:1]}; nc = a[0]; end
        endcase
        ns = r[7];
        nz = (r == 8'h00);
        np = ($countones(r) % 2) == 0;
      end
      2'd1: begin nz = ~a[k]; w = 1'b0; end
      2'd2: r[k] = 1'b0;
      default: r[k] = 1'b1;
    endcase
    return {1'b1, r, ns, nz, np, nc, w, (oc[2:0] == 3'd6)};
  endfunction

  function automatic string tag(input logic [7:0] oc);
    case (oc[7:6])
      2'd0: case (oc[5:3])
              3'd0, 3'd1: return "R3/R8";
              3'd2, 3'd3: return "R4/R8";
              3'd4, 3'd7: return "R5/R8";
              3'd5:       return "R6/R8";
              default:    return "R7/R8";
            endcase
      2'd1: return "R9";
      default: return "R10";
    endcase
  endfunction

  function automatic logic [14:0] observed();
    return {res_valid, result, flag_s, flag_z, flag_p, flag_c, wr_en, mem_sel};
  endfunction

  task automatic run_op(input logic [7:0] oc, input logic [7:0] a,
                        input logic s, input logic z, input logic p, input logic c);
    logic [14:0] exp;
    logic [14:0] got;
    @(negedge clk);
    op_valid = 1'b1; op_code = oc; operand = a;
    sign_in = s; zero_in = z; parity_in = p; carry_in = c;
    exp = model(oc, a, s, z, p, c);
    @(negedge clk);
    op_valid = 1'b0;
    got = observed();
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s op=%h a=%h cin=%b: got %h expected %h", tag(oc), oc, a, c, got, exp);
    end
    // R11 checked on its own field
    tests++;
    if (mem_sel !== (oc[2:0] == 3'd6)) begin
      fails++;
      $display("FAIL R11 op=%h: got %b expected %b", oc, mem_sel, (oc[2:0] == 3'd6));
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    tests++;
    if (observed() !== 15'd0) begin
      fails++;
      $display("FAIL R1: got %h expected %h", observed(), 15'd0);
    end
    // Directed corners
    run_op(8'o060, 8'h80, 1'b0, 1'b1, 1'b1, 1'b0); // R7: 0x01, C=1
    run_op(8'o066, 8'h00, 1'b1, 1'b1, 1'b0, 1'b1); // R7 on memory operand
    run_op(8'o020, 8'h80, 1'b0, 1'b0, 1'b0, 1'b0); // R4: zero result
    run_op(8'o030, 8'h01, 1'b0, 1'b0, 1'b0, 1'b1); // R4: 0x80
    run_op(8'o000, 8'h81, 1'b0, 1'b0, 1'b0, 1'b0); // R3
    run_op(8'o010, 8'h01, 1'b0, 1'b0, 1'b0, 1'b0); // R3
    run_op(8'o050, 8'h81, 1'b0, 1'b0, 1'b0, 1'b0); // R6
    run_op(8'o040, 8'hFF, 1'b0, 1'b0, 1'b0, 1'b0); // R5
    run_op(8'o070, 8'h01, 1'b0, 1'b0, 1'b0, 1'b0); // R5
    run_op(8'o173, 8'h7F, 1'b1, 1'b0, 1'b1, 1'b1); // R9 bit 7 clear
    run_op(8'o103, 8'h01, 1'b0, 1'b1, 1'b0, 1'b0); // R9 bit 0 set
    run_op(8'o277, 8'hFF, 1'b1, 1'b0, 1'b1, 1'b0); // R10 clear bit 7
    run_op(8'o300, 8'h00, 1'b0, 1'b1, 1'b1, 1'b1); // R10 set bit 0
    // R2 idle cycle drops valid and write enable
    @(negedge clk);
    tests++;
    if (res_valid !== 1'b0 || wr_en !== 1'b0) begin
      fails++;
      $display("FAIL R2: got valid=%b wr=%b expected 0 0", res_valid, wr_en);
    end
    // Constrained random
    for (int i = 0; i < 600; i++) begin
      logic [3:0] fl;
      fl = 4'($urandom);
      run_op(8'($urandom), 8'($urandom), fl[3], fl[2], fl[1], fl[0]);
      if (($urandom % 8) == 0) begin
        @(negedge clk);
        tests++;
        if (res_valid !== 1'b0) begin
          fails++;
          $display("FAIL R2: got valid=%b expected 0", res_valid);
        end
      end
    end
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule